// File: doc/BRIEF.md
# Multi-CPU Device Interrupt Router

This block gathers 64 level-sensitive device interrupt lines into one shared pending register and steers them to up to four CPUs. Each CPU owns a 64-bit enable mask. The block keeps a per-CPU filtered copy of the pending bits, equal to that CPU's mask ANDed with the pending register. Each CPU gets one interrupt line, which is high whenever its filtered copy is non-zero.

Software reaches the masks through a plain register port. Each access carries valid, write, address, size and data. The port has no back-pressure: every access is taken in the cycle its valid is high. One cycle later it answers with `rsp_valid`, read data and an error flag. The register index is the byte offset shifted right by 6:

| Index | Register |
|-------|----------|
| 0 to 3 | Masks of CPUs 0 to 3 |
| 4 to 7 | Filtered views of CPUs 0 to 3 |
| 8 | The shared pending register |

The device lines enter an edge-aware capture stage. A rising line sets its pending bit. A falling line clears the bit only if it is set, so a spurious deassert changes nothing.

Top module: `irq_router`

## Requirements
- R1: After reset every mask, the pending register and every filtered view read as zero, and every `cpu_irq` bit is low.
- R2: Pending bit n follows device line n. It takes the line's new level at the first rising clock edge after the change, and index 8 reads it back.
- R3: A 64-bit write (`req_size` = 3) to index c, for c below the CPU count, stores the write data as CPU c's mask. A later read of index c returns that mask.
- R4: Index 4+c always reads CPU c's mask ANDed with the pending register. The view is recomputed at the same edge that a mask write or a device line change takes effect.
- R5: `cpu_irq[c]` is the OR of CPU c's view, registered one cycle after the view. An interrupt is posted either when a device line rises under an enabled mask bit or when a mask write enables an already pending bit.
- R6: `cpu_irq[c]` is withdrawn one cycle after the last enabled pending bit goes away. That happens when the device line falls or when a mask write clears the bit.
- R7: Any access whose size is not 64 bits (`req_size` 0, 1 or 2 for 8, 16 and 32 bits) answers with `rsp_err` = 1 and read data of zero, and changes no register.
- R8: A write to a view index (4 to 7) or to the pending index (8) changes nothing and answers with `rsp_err` = 1.
- R9: Each access gets exactly one response, with `rsp_valid` high in the cycle after `req_valid`. An access to any index above 8 answers with `rsp_err` = 1 and read data of zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_irq | input | 64 | Level device interrupt lines |
| req_valid | input | 1 | Register access present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Byte offset from the block base; the index is bits 9:6 |
| req_size | input | 2 | Access size: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response for the access of the previous cycle |
| rsp_rdata | output | 64 | Read data, zero on error or write |
| rsp_err | output | 1 | Access rejected |
| cpu_irq | output | 4 | Per-CPU device interrupt lines |

## Verification
A stale or mis-recomputed filtered view shows up at a view-index read in the cycle after the access. It also shows up on `cpu_irq` exactly two edges after the device change that should have refreshed the view. A mask that is wrongly written shows in the readback of the very next access. It also shows as a wrong `cpu_irq` once any line under that mask is swept. Sweeping each device line alone against masks of distinct shapes makes a mis-indexed bit show up in the first step that touches it.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int unsigned REG_W = 64;
  localparam int unsigned IDX_SHIFT = 6;
  localparam logic [1:0] SIZE_64 = 2'd3;
endpackage

// File: rtl/irq_capture.sv
module irq_capture #(
  parameter int unsigned LINES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] dev_irq,
  output logic [LINES-1:0] pend_next,
  output logic [LINES-1:0] pend_q
);
  logic [LINES-1:0] rise, fall;

  // Rising lines set pending bits; falling lines clear only bits that are set.
  assign rise      = dev_irq & ~pend_q;
  assign fall      = ~dev_irq & pend_q;
  assign pend_next = (pend_q | rise) & ~fall;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_next;
  end

  assert_pend_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> pend_q == $past(dev_irq));
endmodule

// File: rtl/irq_cpu_slice.sv
module irq_cpu_slice #(
  parameter int unsigned LINES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mask_we,
  input  logic [LINES-1:0] mask_wdata,
  input  logic [LINES-1:0] pend_next,
  input  logic [LINES-1:0] pend_q,
  output logic [LINES-1:0] mask_q,
  output logic [LINES-1:0] view_q,
  output logic             irq_q
);
  logic [LINES-1:0] mask_next;

  assign mask_next = mask_we ? mask_wdata : mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      view_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      mask_q <= mask_next;
      view_q <= mask_next & pend_next;
      irq_q  <= |view_q;
    end
  end

  assert_view_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    view_q == (mask_q & pend_q));
  assert_irq_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> irq_q == $past(|view_q));
  assert_irq_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (view_q == '0) |=> !irq_q);
endmodule

// File: rtl/irq_regport.sv
module irq_regport
  import irq_router_pkg::*;
#(
  parameter int unsigned CPUS   = 4,
  parameter int unsigned ADDR_W = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic                       req_write,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [1:0]                 req_size,
  input  logic [CPUS-1:0][REG_W-1:0] mask_q,
  input  logic [CPUS-1:0][REG_W-1:0] view_q,
  input  logic [REG_W-1:0]           pend_q,
  output logic [CPUS-1:0]            mask_we,
  output logic                       rsp_valid,
  output logic [REG_W-1:0]           rsp_rdata,
  output logic                       rsp_err
);
  localparam int unsigned IDX_W    = ADDR_W - IDX_SHIFT;
  localparam int unsigned VIEW_LO  = CPUS;
  localparam int unsigned PEND_IDX = 2 * CPUS;

  logic [IDX_W-1:0] idx;
  logic             size_ok, is_mask, is_view, is_pend;
  logic             err_c;
  logic [REG_W-1:0] rd_c;

  assign idx     = req_addr[ADDR_W-1:IDX_SHIFT];
  assign size_ok = (req_size == SIZE_64);
  assign is_mask = (32'(idx) < CPUS);
  assign is_view = (32'(idx) >= VIEW_LO) && (32'(idx) < PEND_IDX);
  assign is_pend = (32'(idx) == PEND_IDX);

  genvar c;
  generate
    for (c = 0; c < CPUS; c++) begin : g_we
      assign mask_we[c] = req_valid && req_write && size_ok && (32'(idx) == c);
    end
  endgenerate

  always_comb begin
    rd_c  = '0;
    err_c = 1'b0;
    if (!size_ok)                 err_c = 1'b1;
    else if (is_mask) begin
      if (!req_write) rd_c = mask_q[idx];
    end else if (is_view) begin
      if (req_write) err_c = 1'b1;
      else           rd_c  = view_q[32'(idx) - VIEW_LO];
    end else if (is_pend) begin
      if (req_write) err_c = 1'b1;
      else           rd_c  = pend_q;
    end else                      err_c = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= req_valid ? rd_c : '0;
      rsp_err   <= req_valid && err_c;
    end
  end

  assert_size_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size != SIZE_64) |=> (rsp_err && rsp_rdata == '0));
  assert_ro_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && (is_view || is_pend)) |=> rsp_err);
  assert_one_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> rsp_valid == $past(req_valid));
  assert_we_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mask_we));
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int unsigned CPUS   = 4,
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_W-1:0]  dev_irq,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [REG_W-1:0]  req_wdata,
  output logic              rsp_valid,
  output logic [REG_W-1:0]  rsp_rdata,
  output logic              rsp_err,
  output logic [CPUS-1:0]   cpu_irq
);
  logic [REG_W-1:0]           pend_next, pend_q;
  logic [CPUS-1:0][REG_W-1:0] mask_q, view_q;
  logic [CPUS-1:0]            mask_we;

  irq_capture #(.LINES(REG_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .dev_irq(dev_irq),
    .pend_next(pend_next), .pend_q(pend_q));

  genvar c;
  generate
    for (c = 0; c < CPUS; c++) begin : g_cpu
      irq_cpu_slice #(.LINES(REG_W)) u_slice (
        .clk(clk), .rst_n(rst_n),
        .mask_we(mask_we[c]), .mask_wdata(req_wdata),
        .pend_next(pend_next), .pend_q(pend_q),
        .mask_q(mask_q[c]), .view_q(view_q[c]), .irq_q(cpu_irq[c]));
    end
  endgenerate

  irq_regport #(.CPUS(CPUS), .ADDR_W(ADDR_W)) u_port (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size),
    .mask_q(mask_q), .view_q(view_q), .pend_q(pend_q),
    .mask_we(mask_we),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err));
endmodule

// File: tb/sim_irq_router.sv
`timescale 1ns/1ps
module sim_irq_router;
  localparam int CPUS = 4;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [63:0] dev_irq = '0;
  logic        req_valid = 0, req_write = 0;
  logic [9:0]  req_addr = '0;
  logic [1:0]  req_size = 2'd3;
  logic [63:0] req_wdata = '0;
  logic        rsp_valid, rsp_err;
  logic [63:0] rsp_rdata;
  logic [CPUS-1:0] cpu_irq;

  int checks = 0, fails = 0;
  logic [63:0] mmask [CPUS];
  logic [63:0] rd;
  logic        er;

  always #2.5 clk = ~clk;

  irq_router u0 (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input int idx, input logic [1:0] sz,
                     input logic [63:0] d, output logic [63:0] r, output logic e);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = 10'(idx << 6) | 10'(idx & 7);
    req_size = sz; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
    checks++;
    if (rsp_valid !== 1'b1) begin
      fails++;
      $display("FAIL R9 actual=%b expected=1", rsp_valid);
    end
    r = rsp_rdata; e = rsp_err;
  endtask

  function automatic logic [CPUS-1:0] exp_irq(input logic [63:0] dv);
    logic [CPUS-1:0] v;
    for (int c = 0; c < CPUS; c++) v[c] = |(mmask[c] & dv);
    return v;
  endfunction

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    check("R1 irq", 64'(cpu_irq), 0);
    for (int i = 0; i <= 8; i++) begin
      acc(0, i, 2'd3, 0, rd, er);
      check("R1 reg", rd, 0);
    end
    // R3: program masks of distinct shapes
    mmask[0] = '1; mmask[1] = 64'h5555_5555_5555_5555;
    mmask[2] = 64'hFFFF_FFFF_0000_0000; mmask[3] = '0;
    for (int c = 0; c < CPUS; c++) acc(1, c, 2'd3, mmask[c], rd, er);
    for (int c = 0; c < CPUS; c++) begin
      acc(0, c, 2'd3, 0, rd, er);
      check("R3 mask readback", rd, mmask[c]);
    end
    // R2/R4/R5/R6: sweep each device line alone
    for (int ln = 0; ln < 64; ln++) begin
      @(negedge clk); dev_irq = 64'd1 << ln;
      @(negedge clk); @(negedge clk);
      check("R5 irq on line", 64'(cpu_irq), 64'(exp_irq(dev_irq)));
      acc(0, 4 + (ln % CPUS), 2'd3, 0, rd, er);
      check("R4 view", rd, mmask[ln % CPUS] & dev_irq);
      if (ln % 16 == 0) begin
        acc(0, 8, 2'd3, 0, rd, er);
        check("R2 pending", rd, dev_irq);
      end
    end
    @(negedge clk); dev_irq = '0;
    @(negedge clk); @(negedge clk);
    check("R6 withdraw on deassert", 64'(cpu_irq), 0);
    // R5/R6 via mask writes with a pending line
    @(negedge clk); dev_irq = 64'h0000_0100_0000_0000;
    @(negedge clk); @(negedge clk);
    check("R5 cpu3 quiet", 64'(cpu_irq[3]), 0);
    mmask[3] = 64'h0000_0100_0000_0000;
    acc(1, 3, 2'd3, mmask[3], rd, er);
    acc(0, 7, 2'd3, 0, rd, er);
    check("R4 view after mask write", rd, 64'h0000_0100_0000_0000);
    check("R5 post by mask write", 64'(cpu_irq[3]), 1);
    mmask[3] = '0;
    acc(1, 3, 2'd3, 0, rd, er);
    @(negedge clk);
    check("R6 withdraw by mask write", 64'(cpu_irq[3]), 0);
    // R7: narrow accesses rejected
    for (int s = 0; s < 3; s++) begin
      acc(1, 3, 2'(s), 64'hDEAD, rd, er);
      check("R7 err", 64'(er), 1);
      acc(0, 0, 2'(s), 0, rd, er);
      check("R7 rdata", rd, 0);
    end
    acc(0, 3, 2'd3, 0, rd, er);
    check("R7 mask unchanged", rd, 0);
    // R8: writes to read-only indices
    acc(1, 4, 2'd3, 64'h1234, rd, er);
    check("R8 view write err", 64'(er), 1);
    acc(1, 8, 2'd3, '1, rd, er);
    check("R8 pend write err", 64'(er), 1);
    acc(0, 4, 2'd3, 0, rd, er);
    check("R8 view unchanged", rd, 64'h0000_0100_0000_0000);
    acc(0, 8, 2'd3, 0, rd, er);
    check("R8 pend unchanged", rd, 64'h0000_0100_0000_0000);
    // R9: unmapped index
    acc(0, 12, 2'd3, 0, rd, er);
    check("R9 unmapped err", 64'(er), 1);
    check("R9 unmapped rdata", rd, 0);
    @(negedge clk);
    check("R9 single response", 64'(rsp_valid), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule